// File: doc/BRIEF.md
# Staggered Conversion-Section Phase Sequencer

This block drives the control strobes of a bank of sixteen identical successive-approximation converter sections that take turns on one analog input. A single shared phase counter, stepped on every rising clock edge, is decoded once per section with that section's index as an offset. Each section therefore walks the same sixteen-cycle job list: zero-reference sample, offset (auto-zero) compare, gain calibration compare, input sample, nine bit trials, two idle slots and a result hand-off. Every section runs one clock behind the section below it.

Because the offsets cover every residue of the frame, exactly one section takes the input on every clock and exactly one section hands its result to the output multiplexer. The block names that section on a 4-bit index, which the downstream multiplexer uses as its select. A separate timer counts clocks from reset and raises a calibration-settled flag once the closed-loop trims have had enough cycles to converge.

Top module: `sar_phase_seq`

## Requirements
- R1: A synchronous active-high reset puts section 0 in frame slot 1 on the next clock: `zref_smp` reads 16'h0001, `in_smp` reads 16'h2000 (section 13), `xfer_idx` reads 1 and `cal_done` reads 0.
- R2: For a section in frame slot f (1 to 16), only `zref_smp` is high in slot 1, only `az_cmp` in slot 2, only `cal_cmp` in slot 3 and only `in_smp` in slot 4. Bit s of each of these vectors belongs to section s.
- R3: In slots 5 to 13 one bit-trial strobe is high, stepping from result bit 8 (slot 5) down to bit 0 (slot 13). In slots 14 and 15 no strobe of that section is high. The strobe for result bit b of section s is `bit_step[s*9+b]`.
- R4: Only `xfer_en[s]` is high while section s is in slot 16.
- R5: Section s+1 is one clock behind section s (modulo 16), so `in_smp` has exactly one bit set on every clock, and that bit moves up one position per clock.
- R6: Every strobe pattern repeats exactly every 16 clocks.
- R7: `xfer_idx` equals the number of the section that is in slot 16 on the current clock.
- R8: `cal_done` is low for the first 9,999 clocks after reset is released, goes high on the 10,000th rising edge, and stays high until the next reset.
- R9: Asserting reset in the middle of operation restarts the schedule at section 0, slot 1, and clears the calibration count, so `cal_done` drops and again needs 10,000 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state moves on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| zref_smp | output | 16 | Per-section zero-reference sample enable |
| az_cmp | output | 16 | Per-section auto-zero compare enable |
| cal_cmp | output | 16 | Per-section calibration compare enable |
| in_smp | output | 16 | Per-section analog input sample enable |
| bit_step | output | 144 | Per-section bit-trial strobes, section s at bits s*9+8 down to s*9 |
| xfer_en | output | 16 | Per-section result transfer enable |
| xfer_idx | output | 4 | Number of the section now transferring its result |
| cal_done | output | 1 | Calibration settling period has elapsed |

## Verification
A wrong phase count shows up at the ports on the very next clock. The one-hot `in_smp` bit is in the wrong place, and `xfer_idx` no longer points at the set bit of `xfer_en`. Both are compared on every cycle against a schedule computed from the slot rules. A wrong per-section decode appears within one 16-clock frame as a strobe in the wrong slot or a bit trial out of MSB-to-LSB order. A calibration counter that is off by even one clock is caught by checking `cal_done` on exactly the clocks either side of the 10,000th edge, both after power-up and after a reset in mid-run.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Job performed by one section in one slot of its frame
    typedef enum logic [2:0] {
        JOB_ZREF  = 3'd0,
        JOB_AZ    = 3'd1,
        JOB_CAL   = 3'd2,
        JOB_SAMP  = 3'd3,
        JOB_TRIAL = 3'd4,
        JOB_IDLE  = 3'd5,
        JOB_XFER  = 3'd6
    } job_e;

    // Number of slots that come before the first bit trial
    localparam int unsigned PRE_SLOTS = 4;

    // Map a zero-based slot to its job; the final slot hands off the result
    function automatic job_e slot_job(input int unsigned slot,
                                      input int unsigned frame,
                                      input int unsigned sar_w);
        job_e j;
        if (slot == 0)                          j = JOB_ZREF;
        else if (slot == 1)                     j = JOB_AZ;
        else if (slot == 2)                     j = JOB_CAL;
        else if (slot == 3)                     j = JOB_SAMP;
        else if (slot == frame - 1)             j = JOB_XFER;
        else if (slot < PRE_SLOTS + sar_w)      j = JOB_TRIAL;
        else                                    j = JOB_IDLE;
        return j;
    endfunction

    // Result bit under trial in a trial slot, MSB first
    function automatic int unsigned trial_bit(input int unsigned slot,
                                              input int unsigned sar_w);
        return sar_w - 1 - (slot - PRE_SLOTS);
    endfunction

endpackage

// File: rtl/seq_phase_ring.sv
module seq_phase_ring #(
    parameter int unsigned NSECT = 16,
    localparam int unsigned PW   = $clog2(NSECT)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase
);

    typedef struct packed {
        logic [PW-1:0] ph;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (rst)
            ring_d.ph = '0;
        else if (ring_q.ph == PW'(NSECT - 1))
            ring_d.ph = '0;
        else
            ring_d.ph = ring_q.ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    assign phase = ring_q.ph;

    // R6
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ring_q.ph == PW'(NSECT - 1)) |=> (ring_q.ph == '0));

endmodule

// File: rtl/seq_sect_strobe.sv
module seq_sect_strobe
    import sar_seq_pkg::*;
#(
    parameter int unsigned NSECT   = 16,
    parameter int unsigned SAR_W   = 9,
    parameter int unsigned SECT_ID = 0,
    localparam int unsigned PW     = $clog2(NSECT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    phase,
    output logic             zref,
    output logic             az,
    output logic             cal,
    output logic             samp,
    output logic [SAR_W-1:0] trial,
    output logic             xfer
);

    int unsigned slot;
    int unsigned bidx;
    job_e        job;

    always_comb begin
        if (int'(phase) >= int'(SECT_ID))
            slot = int'(phase) - SECT_ID;
        else
            slot = int'(phase) + NSECT - SECT_ID;
        job  = slot_job(slot, NSECT, SAR_W);
        bidx = (job == JOB_TRIAL) ? trial_bit(slot, SAR_W) : 0;

        zref  = (job == JOB_ZREF);
        az    = (job == JOB_AZ);
        cal   = (job == JOB_CAL);
        samp  = (job == JOB_SAMP);
        xfer  = (job == JOB_XFER);
        trial = '0;
        if (job == JOB_TRIAL)
            trial = {{(SAR_W - 1){1'b0}}, 1'b1} << bidx;
    end

    // R2
    zref_then_az_chk: assert property (@(posedge clk) disable iff (rst)
        zref |=> az);
    // R2
    az_then_cal_chk: assert property (@(posedge clk) disable iff (rst)
        az |=> cal);
    // R2
    cal_then_samp_chk: assert property (@(posedge clk) disable iff (rst)
        cal |=> samp);
    // R3
    samp_then_msb_chk: assert property (@(posedge clk) disable iff (rst)
        samp |=> trial[SAR_W-1]);
    // R3
    trial_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trial));
    // R4
    xfer_then_zref_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> zref);

endmodule

// File: rtl/seq_cal_timer.sv
module seq_cal_timer #(
    parameter int unsigned CAL_CYCLES = 10000,
    localparam int unsigned CW        = $clog2(CAL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic done
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cal_t;

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (rst) begin
            cal_d.cnt  = '0;
            cal_d.done = 1'b0;
        end else begin
            if (cal_q.cnt != CW'(CAL_CYCLES))
                cal_d.cnt = cal_q.cnt + 1'b1;
            cal_d.done = cal_q.done | (cal_d.cnt == CW'(CAL_CYCLES));
        end
    end

    always_ff @(posedge clk) begin
        cal_q <= cal_d;
    end

    assign done = cal_q.done;

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cal_q.done |=> cal_q.done);
    // R8
    done_only_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cal_q.done |-> (cal_q.cnt == CW'(CAL_CYCLES)));

endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq #(
    parameter int unsigned NSECT      = 16,
    parameter int unsigned SAR_W      = 9,
    parameter int unsigned CAL_CYCLES = 10000,
    localparam int unsigned PW        = $clog2(NSECT)
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [NSECT-1:0]       zref_smp,
    output logic [NSECT-1:0]       az_cmp,
    output logic [NSECT-1:0]       cal_cmp,
    output logic [NSECT-1:0]       in_smp,
    output logic [NSECT*SAR_W-1:0] bit_step,
    output logic [NSECT-1:0]       xfer_en,
    output logic [PW-1:0]          xfer_idx,
    output logic                   cal_done
);

    logic [PW-1:0] phase;

    seq_phase_ring #(.NSECT(NSECT)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        seq_sect_strobe #(
            .NSECT   (NSECT),
            .SAR_W   (SAR_W),
            .SECT_ID (s)
        ) u_strobe (
            .clk   (clk),
            .rst   (rst),
            .phase (phase),
            .zref  (zref_smp[s]),
            .az    (az_cmp[s]),
            .cal   (cal_cmp[s]),
            .samp  (in_smp[s]),
            .trial (bit_step[s*SAR_W +: SAR_W]),
            .xfer  (xfer_en[s])
        );
    end

    // Section in its last slot sits NSECT-1 behind the phase, i.e. one ahead
    always_comb begin
        if (phase == PW'(NSECT - 1))
            xfer_idx = '0;
        else
            xfer_idx = phase + 1'b1;
    end

    seq_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk  (clk),
        .rst  (rst),
        .done (cal_done)
    );

    // R5
    one_sampler_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(in_smp) == 1);
    // R5
    sampler_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (in_smp == {$past(in_smp[NSECT-2:0]), $past(in_smp[NSECT-1])}));
    // R7
    xfer_idx_matches_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_en[xfer_idx] && ($countones(xfer_en) == 1));

endmodule

// File: tb/tb_sar_phase_seq.sv
`timescale 1ns/1ps
module tb_sar_phase_seq;

    localparam int NS  = 16;
    localparam int SW  = 9;
    localparam int CAL = 10000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NS-1:0]   zref_smp, az_cmp, cal_cmp, in_smp, xfer_en;
    logic [NS*SW-1:0] bit_step;
    logic [3:0]      xfer_idx;
    logic            cal_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sar_phase_seq dut (
        .clk      (clk),
        .rst      (rst),
        .zref_smp (zref_smp),
        .az_cmp   (az_cmp),
        .cal_cmp  (cal_cmp),
        .in_smp   (in_smp),
        .bit_step (bit_step),
        .xfer_en  (xfer_en),
        .xfer_idx (xfer_idx),
        .cal_done (cal_done)
    );

    typedef struct {
        int               j;
        string            tag;
        logic [NS-1:0]    zref, az, cal, samp, xfer;
        logic [NS*SW-1:0] trial;
        logic [3:0]       idx;
        logic             done;
    } exp_t;

    exp_t sb[$];

    // Expected outputs j clocks after the last reset edge, from the slot rules
    function automatic exp_t model(int j, string tag);
        exp_t e;
        int p;
        e.j = j; e.tag = tag;
        e.zref = '0; e.az = '0; e.cal = '0; e.samp = '0; e.xfer = '0; e.trial = '0;
        p = j % NS;
        for (int s = 0; s < NS; s++) begin
            int f;
            f = (p - s + NS) % NS;            // zero-based frame slot
            if (f == 0)  e.zref[s] = 1'b1;
            if (f == 1)  e.az[s]   = 1'b1;
            if (f == 2)  e.cal[s]  = 1'b1;
            if (f == 3)  e.samp[s] = 1'b1;
            if (f >= 4 && f <= 12) e.trial[s*SW + (12 - f)] = 1'b1;
            if (f == 15) e.xfer[s] = 1'b1;
        end
        e.idx  = 4'((p + 1) % NS);
        e.done = (j >= CAL);
        return e;
    endfunction

    task automatic check(string req, string what, int j, logic [NS*SW-1:0] act, logic [NS*SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, j, act, exp);
        end
    endtask

    // Monitor: pops one expected record per clock and compares away from the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            string r2, r3, r4, r5, r7, r8;
            e = sb.pop_front();
            r2 = (e.tag == "") ? "R2" : e.tag;
            r3 = (e.tag == "") ? "R3" : e.tag;
            r4 = (e.tag == "") ? "R4" : e.tag;
            r5 = (e.tag == "") ? "R5" : e.tag;
            r7 = (e.tag == "") ? "R7" : e.tag;
            r8 = (e.tag == "") ? "R8" : e.tag;
            check(r2, "zref_smp", e.j, (NS*SW)'(zref_smp), (NS*SW)'(e.zref));
            check(r2, "az_cmp",   e.j, (NS*SW)'(az_cmp),   (NS*SW)'(e.az));
            check(r2, "cal_cmp",  e.j, (NS*SW)'(cal_cmp),  (NS*SW)'(e.cal));
            check(r5, "in_smp",   e.j, (NS*SW)'(in_smp),   (NS*SW)'(e.samp));
            check(r3, "bit_step", e.j, bit_step,           e.trial);
            check(r4, "xfer_en",  e.j, (NS*SW)'(xfer_en),  (NS*SW)'(e.xfer));
            check(r7, "xfer_idx", e.j, (NS*SW)'(xfer_idx), (NS*SW)'(e.idx));
            check(r8, "cal_done", e.j, (NS*SW)'(cal_done), (NS*SW)'(e.done));
        end
    end

    // Driver: hold reset for n edges, expecting the restart state (R1 / R9)
    task automatic do_reset(int n, string tag);
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            sb.push_back(model(0, tag));
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver: run n free clocks; R6 is covered by runs spanning several frames
    task automatic run(int n);
        for (int j = 1; j <= n; j++) begin
            @(posedge clk);
            sb.push_back(model(j, ""));
        end
    endtask

    initial begin
        do_reset(3, "R1");
        run(48);                 // three full frames: R2..R7, R6 repetition
        do_reset(2, "R9");       // mid-run restart clears schedule and count
        run(CAL + 6);            // R8 edge at exactly 10,000 and stickiness
        do_reset(1, "R9");       // cal_done must drop again
        run(20);
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule